// File: doc/BRIEF.md
# Trimmed One-Second Tick Generator

This block turns a stream of oscillator count enables at 32.768 kHz into a one-second tick. It corrects the average length of that second by a small programmable amount in parts per million. The oscillator itself is never tuned. Instead, some seconds are made one count shorter or one count longer than nominal, and these corrected seconds are spread out so that the error averages away over many seconds.

The correction comes from a three-bit trim field that is written through a simple register port. The field holds a direction bit and two weighted magnitude bits, which together cover -30 to +30 ppm in 10 ppm steps. A fractional accumulator collects the requested correction once per second. Whenever the accumulator holds at least one whole count, the second that is just starting is adjusted.

A status output is high for the whole of any second that was adjusted. The block runs on a fast system clock. The oscillator count arrives as a one-cycle enable, so the nominal count, the accumulator scale and all widths are parameters.

Top module: `osc_second_gen`

## Requirements
- R1: While reset is low and in the cycle after it is released, `tick_o` and `adj_o` are low. The first second after reset lasts exactly NOM_COUNT oscillator counts and is not adjusted.
- R2: `tick_o` is a single-cycle pulse. It rises in the clock cycle after the edge that consumes the final oscillator count of a second. An unadjusted second lasts NOM_COUNT counts.
- R3: Only clock cycles with `osc_en` high advance the second. Idle cycles between enables do not change the measured length of a second in counts.
- R4: Trim encoding is as follows. Bit 2 is the direction: 0 shortens seconds (positive compensation) and 1 lengthens them. Bit 1 is worth one unit of 10 ppm. Bit 0 is worth two units of 10 ppm.
- R5: At every second boundary, the accumulator gains units × NOM_COUNT. If the result is at least FRAC_SCALE, FRAC_SCALE is subtracted and the second now starting is adjusted. Otherwise that second is nominal.
- R6: An adjusted second lasts NOM_COUNT-1 counts when bit 2 is 0, and NOM_COUNT+1 counts when bit 2 is 1.
- R7: A trim write is held and used only from the next second boundary on. The second running when the write arrives keeps its length.
- R8: A new trim value does not clear the accumulator. The remainder left by earlier seconds carries into the next decision, including across a change of direction.
- R9: With both magnitude bits zero, every second lasts NOM_COUNT counts, whatever the direction bit is.
- R10: `adj_o` is high for exactly the seconds that are adjusted. It changes only in the cycle in which `tick_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per oscillator count |
| trim_wr | input | 1 | Write strobe for the trim field |
| trim_din | input | 3 | Trim value: direction in bit 2, magnitude in bits 1 and 0 |
| tick_o | output | 1 | One-cycle pulse at each second boundary |
| adj_o | output | 1 | High during a second that was shortened or lengthened |

## Verification
The hardest situation to reach is a corrected second whose threshold crossing depends on a remainder left by an earlier trim value. The worst case is when that earlier trim had the opposite direction. At the default scale, thresholds are crossed only after many real seconds. The bench therefore shrinks both the nominal count and the accumulator scale, so that crossings happen within a few seconds. It then rewrites the trim mid-second in a fixed order: zero magnitude, +20 ppm, -30 ppm, -10 ppm and zero again. Each change leaves a known remainder for the next setting to consume. One phase gates `osc_en` with idle cycles, so that lengths are counted in enables and not in clocks.

// File: rtl/osc_trim_pkg.sv
// Package: shared trim field layout and correction kinds.
// Assumes the trim field bit order is direction, 10 ppm unit, 20 ppm unit.
package osc_trim_pkg;

    // Bit 2 = direction (1 lengthens), bit 1 = one unit, bit 0 = two units.
    typedef struct packed {
        logic neg;
        logic u10;
        logic u20;
    } trim_t;

    // Kind of length change applied to the current second.
    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_SHORT = 2'd1,
        CORR_LONG  = 2'd2
    } corr_e;

    // Magnitude in 10 ppm units: u10 weighs 1, u20 weighs 2.
    function automatic logic [1:0] trim_units(trim_t t);
        return {t.u20, t.u10};
    endfunction

endpackage

// File: rtl/trim_hold.sv
// Module: trim_hold
// Holds the most recent trim write. The accumulator samples the held value
// only at a second boundary, so a write never disturbs the running second.
// Assumes writes are single-cycle strobes.
module trim_hold
    import osc_trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  trim_t din,
    output trim_t held
);

    trim_t held_q;

    // Capture the written trim; clear to zero magnitude on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (wr) begin
            held_q <= din;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/frac_accum.sv
// Module: frac_accum
// Fractional correction accumulator. At each boundary it adds the trim
// magnitude times NOM_COUNT, in units of FRAC_SCALE per whole count. When a
// whole count is reached, it marks the next second as shortened or
// lengthened. Assumes 3*NOM_COUNT < FRAC_SCALE, so one subtraction is enough.
module frac_accum
    import osc_trim_pkg::*;
#(
    parameter int NOM_COUNT  = 32768,
    parameter int FRAC_SCALE = 100000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bound,
    input  trim_t trim,
    output corr_e corr
);

    localparam int ACC_W = $clog2(FRAC_SCALE + 3 * NOM_COUNT + 1);
    localparam logic [ACC_W-1:0] NOM_W   = ACC_W'(NOM_COUNT);
    localparam logic [ACC_W-1:0] SCALE_W = ACC_W'(FRAC_SCALE);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic             whole;
    corr_e            corr_q;

    // Correction to add this boundary, and the running total.
    always_comb begin
        step  = ACC_W'(trim_units(trim)) * NOM_W;
        sum   = acc_q + step;
        whole = (sum >= SCALE_W);
    end

    // Update the remainder and decide the kind of the starting second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            corr_q <= CORR_NONE;
        end else if (bound) begin
            if (whole) begin
                acc_q  <= sum - SCALE_W;
                corr_q <= trim.neg ? CORR_LONG : CORR_SHORT;
            end else begin
                acc_q  <= sum;
                corr_q <= CORR_NONE;
            end
        end
    end

    assign corr = corr_q;

endmodule

// File: rtl/sec_divider.sv
// Module: sec_divider
// Counts oscillator enables up to the length chosen for the current second.
// It flags the boundary combinationally and emits a registered tick.
// Assumes NOM_COUNT >= 3.
module sec_divider
    import osc_trim_pkg::*;
#(
    parameter int NOM_COUNT = 32768
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  osc_en,
    input  corr_e corr,
    output logic  bound,
    output logic  tick
);

    localparam int CNT_W = $clog2(NOM_COUNT + 2);
    localparam logic [CNT_W-1:0] LAST_NOM   = CNT_W'(NOM_COUNT - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(NOM_COUNT - 2);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(NOM_COUNT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic             tick_q;

    // Index of the final count for the current second's kind.
    always_comb begin
        unique case (corr)
            CORR_SHORT: last_idx = LAST_SHORT;
            CORR_LONG:  last_idx = LAST_LONG;
            default:    last_idx = LAST_NOM;
        endcase
        bound = osc_en && (cnt_q == last_idx);
    end

    // Advance on each enable and wrap at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bound) begin
            cnt_q <= '0;
        end else if (osc_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered one-cycle tick after the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= bound;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/osc_second_gen.sv
// Module: osc_second_gen (top)
// Produces a one-second tick from oscillator count enables. The average
// period is trimmed by occasional one-count-short or one-count-long seconds.
// Assumes osc_en is one system clock wide per oscillator count.
module osc_second_gen
    import osc_trim_pkg::*;
#(
    parameter int NOM_COUNT  = 32768,
    parameter int FRAC_SCALE = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       trim_wr,
    input  logic [2:0] trim_din,
    output logic       tick_o,
    output logic       adj_o
);

    trim_t held;
    corr_e corr;
    logic  bound;
    logic  tick;

    trim_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (trim_wr),
        .din   (trim_t'(trim_din)),
        .held  (held)
    );

    frac_accum #(
        .NOM_COUNT  (NOM_COUNT),
        .FRAC_SCALE (FRAC_SCALE)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .bound (bound),
        .trim  (held),
        .corr  (corr)
    );

    sec_divider #(
        .NOM_COUNT (NOM_COUNT)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .corr   (corr),
        .bound  (bound),
        .tick   (tick)
    );

    // Status is high whenever the running second is not nominal.
    always_comb begin
        tick_o = tick;
        adj_o  = (corr != CORR_NONE);
    end

endmodule

// File: rtl/osc_second_gen_chk.sv
// Module: osc_second_gen_chk
// Port-level checker. It measures each second in oscillator enables and
// relates that length and the status bit to the tick.
module osc_second_gen_chk #(
    parameter int NOM_COUNT = 32768
) (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic tick_o,
    input logic adj_o
);

    logic [31:0] len_q;

    // Enables consumed since the previous tick, including the boundary one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (tick_o) begin
            len_q <= {31'd0, osc_en};
        end else if (osc_en) begin
            len_q <= len_q + 32'd1;
        end
    end

    // R2: the tick lasts one cycle.
    a_r2_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R10: status moves only together with the tick.
    a_r10_adj_moves_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |-> $stable(adj_o));

    // R5: an unadjusted second is nominal length.
    a_r5_plain_second_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !$past(adj_o)) |-> (len_q == 32'(NOM_COUNT)));

    // R6: an adjusted second differs from nominal by exactly one count.
    a_r6_adjusted_one_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(adj_o)) |->
        (len_q == 32'(NOM_COUNT - 1) || len_q == 32'(NOM_COUNT + 1)));

endmodule

bind osc_second_gen osc_second_gen_chk #(
    .NOM_COUNT (NOM_COUNT)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .tick_o (tick_o),
    .adj_o  (adj_o)
);

// File: tb/sim_osc_second_gen.sv
// Scoreboard bench: the driver pushes the expected length, status and tag
// of each second. The monitor measures seconds at the ports and compares.
module sim_osc_second_gen;

    localparam int NOM   = 20;
    localparam int SCALE = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       trim_wr = 1'b0;
    logic [2:0] trim_din = 3'b000;
    logic       tick_o;
    logic       adj_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    running = 1'b0;
    bit    gap_mode = 1'b0;
    int    gcnt = 0;
    int    acc_m = 0;
    int    seen = 0;
    bit    prev_adj = 1'b0;
    int    q_len[$];
    bit    q_adj[$];
    string q_tag[$];
    event  tick_ev;

    osc_second_gen #(.NOM_COUNT(NOM), .FRAC_SCALE(SCALE)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .trim_wr  (trim_wr),
        .trim_din (trim_din),
        .tick_o   (tick_o),
        .adj_o    (adj_o)
    );

    always #5 clk = ~clk;

    // Oscillator enable: always on, or two of every three cycles in gap mode.
    always @(negedge clk) begin
        gcnt = gcnt + 1;
        osc_en = running && (!gap_mode || (gcnt % 3 != 0));
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: count enables, and compare each completed second.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            seen = seen + (osc_en ? 1 : 0);
            if (tick_o) begin
                if (q_len.size() == 0) begin
                    total = total + 1;
                    bad = bad + 1;
                    $display("FAIL R2: unexpected tick, actual=1 expected=0");
                end else begin
                    int    el;
                    bit    ea;
                    string et;
                    el = q_len.pop_front();
                    ea = q_adj.pop_front();
                    et = q_tag.pop_front();
                    total = total + 1;
                    if (seen != el) begin
                        bad = bad + 1;
                        $display("FAIL %s: second length actual=%0d expected=%0d", et, seen, el);
                    end
                    total = total + 1;
                    if (prev_adj != ea) begin
                        bad = bad + 1;
                        $display("FAIL %s R10: adj actual=%0d expected=%0d", et, prev_adj, ea);
                    end
                end
                seen = 0;
                -> tick_ev;
            end
            prev_adj = adj_o;
        end
    end

    // Model of one boundary: push the second that the given trim starts.
    task automatic push_second(input logic [2:0] t, input string tag);
        int units;
        units = (t[1] ? 1 : 0) + (t[0] ? 2 : 0);
        acc_m = acc_m + units * NOM;
        if (acc_m >= SCALE) begin
            acc_m = acc_m - SCALE;
            q_len.push_back(t[2] ? NOM + 1 : NOM - 1);
            q_adj.push_back(1'b1);
        end else begin
            q_len.push_back(NOM);
            q_adj.push_back(1'b0);
        end
        q_tag.push_back(tag);
    endtask

    // Driver: write the trim mid-second, predict the next second, wait.
    task automatic do_sec(input logic [2:0] t, input string tag);
        @(negedge clk);
        trim_wr = 1'b1;
        trim_din = t;
        @(negedge clk);
        trim_wr = 1'b0;
        push_second(t, tag);
        @(tick_ev);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        total = total + 1;
        if (tick_o !== 1'b0 || adj_o !== 1'b0) begin
            bad = bad + 1;
            $display("FAIL R1: in reset tick/adj actual=%b%b expected=00", tick_o, adj_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total = total + 1;
        if (tick_o !== 1'b0 || adj_o !== 1'b0) begin
            bad = bad + 1;
            $display("FAIL R1: after reset tick/adj actual=%b%b expected=00", tick_o, adj_o);
        end
        // First second is nominal; the write during it must not shorten it (R7).
        q_len.push_back(NOM);
        q_adj.push_back(1'b0);
        q_tag.push_back("R1 R7");
        running = 1'b1;
        // Zero magnitude, direction bit set (R9).
        for (int i = 0; i < 3; i++) do_sec(3'b100, "R9 R2");
        // +20 ppm: bit 0 is two units, shortened seconds (R4, R5, R6).
        for (int i = 0; i < 8; i++) do_sec(3'b001, "R4 R5 R6");
        // -30 ppm with idle cycles; the remainder carries over (R3, R8).
        gap_mode = 1'b1;
        for (int i = 0; i < 6; i++) do_sec(3'b111, "R3 R6 R8");
        gap_mode = 1'b0;
        // -10 ppm: bit 1 is one unit, the remainder is kept (R4, R8).
        for (int i = 0; i < 4; i++) do_sec(3'b110, "R4 R8");
        // Zero magnitude with a remainder present stays nominal (R9).
        for (int i = 0; i < 3; i++) do_sec(3'b000, "R9");
        @(tick_ev);
        total = total + 1;
        if (q_len.size() != 0) begin
            bad = bad + 1;
            $display("FAIL R2: pending seconds actual=%0d expected=0", q_len.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule